// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block conditions sixteen synchronous interrupt request inputs, arranged as two groups of eight, into the request bits seen by downstream interrupt controllers. Each line is set to edge or level triggering by one bit of its group's trigger-select register. Software writes these registers and can read them back. A rising input always latches a request. A level line's request follows the input while the input is active and is dropped when the input falls. An edge line's request stays latched until an acknowledge for that pin finds the input inactive.

Some lines cannot be made level-triggered. In group 0 these are lines 0, 1 and 2. In group 1 they are lines 8 and 13. The register write masks drop the bits for these lines. Input transitions are only acted on once the owning group's controller reports that it has finished initialization. Priority, masking and vector generation happen downstream.

All ports are plain control and status signals. There is no data stream and no back-pressure: a write, an acknowledge and every input sample each take effect at the rising clock edge where they are present.

Top module: `irq_trigger_latch`

## Requirements
- R1: When a line's group is ready and its input is sampled high after being low on the previous clock, its `req_out` bit is 1 in the cycle after that edge, in either trigger mode.
- R2: For a level line in a ready group, `req_out` is 1 in the cycle after every clock at which its input is sampled high.
- R3: A high-to-low input transition in a ready group clears the request of a level line. On an edge line the request stays set after the input drops.
- R4: `ack_valid` with `ack_pin` = 8*group + line clears that line's request if its input is low at that edge. If the input is high, the request is left set.
- R5: Bit i of the group-0 trigger register selects level mode (1) or edge mode (0) for line i. Writes are ANDed with 0xF8, so bits 0 to 2 always read 0.
- R6: Bit i of the group-1 trigger register selects the mode of line 8+i. Writes are ANDed with 0xDE, so bits 0 and 5 (lines 8 and 13) always read 0.
- R7: Both trigger registers reset to 0x00. `cfg_rd_data` shows the stored value of the group selected by `cfg_rd_grp` without delay. A write is applied at the clock edge.
- R8: A one-cycle high pulse on an edge line leaves its request latched after the pulse ends.
- R9: While a group's `grp_ready` bit is 0, input transitions do not change its request bits. The previous-input copy keeps tracking, so a line held high as the group becomes ready gives no edge.
- R10: After reset all request bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Synchronous request inputs, line 8*g+i in group g |
| grp_ready | input | 2 | Per-group flag: the controller has finished initialization |
| cfg_wr_en | input | 1 | Trigger register write strobe |
| cfg_wr_grp | input | 1 | Group selected for the write |
| cfg_wr_data | input | 8 | Write value before masking |
| cfg_rd_grp | input | 1 | Group selected for read-back |
| cfg_rd_data | output | 8 | Stored trigger register of the selected group |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_pin | input | 4 | Pin number of the acknowledge |
| req_out | output | 16 | Latched request bits |

## Verification
The bench aims at the places where the two trigger modes behave differently. A design that clears on any falling edge would lose a pulsed edge request. A design that ignores the input level on acknowledge would drop a request whose input is still high. A design that leaves out the write masks would let lines 0, 1, 2, 8 or 13 read back as level. The bench also raises a line while its group is not ready and then makes the group ready with the input still high. A design that freezes its previous-input copy there would report a false edge.

// File: rtl/irql_pkg.sv
package irql_pkg;
  localparam int unsigned LINES_PER_GRP = 8;
  localparam int unsigned NUM_GRP       = 2;
  localparam int unsigned NUM_LINES     = LINES_PER_GRP * NUM_GRP;
  localparam int unsigned LINE_W        = $clog2(LINES_PER_GRP);
  localparam int unsigned GRP_W         = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int unsigned PIN_W         = $clog2(NUM_LINES);

  typedef logic [LINES_PER_GRP-1:0] grp_vec_t;
  typedef logic [NUM_LINES-1:0]     line_vec_t;

  // default write masks: group 0 keeps lines 0..2 edge, group 1 keeps 8 and 13 edge
  localparam line_vec_t DEFAULT_WR_MASK = 16'hDEF8;
endpackage

// File: rtl/irql_line.sv
module irql_line (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  input  logic ready_i,
  input  logic level_i,
  input  logic ack_i,
  output logic req_o
);
  logic prev_q;
  logic req_q;
  logic rise, fall, set_req, clr_req;

  always_comb begin
    rise    = ready_i & in_i & ~prev_q;
    fall    = ready_i & ~in_i & prev_q;
    set_req = rise | (ready_i & level_i & in_i);
    clr_req = (fall & level_i) | (ack_i & ~in_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= in_i;
      if (set_req)      req_q <= 1'b1;
      else if (clr_req) req_q <= 1'b0;
    end
  end

  assign req_o = req_q;

  p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && in_i && !prev_q) |=> req_q);
  p_level_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && level_i && in_i) |=> req_q);
  p_edge_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && req_q && !ack_i) |=> req_q);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !in_i) |=> !req_q);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_i && !ack_i) |=> $stable(req_q));
endmodule

// File: rtl/irql_group.sv
module irql_group
  import irql_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  grp_vec_t in_i,
  input  logic     ready_i,
  input  grp_vec_t level_i,
  input  grp_vec_t ack_i,
  output grp_vec_t req_o
);
  for (genvar i = 0; i < LINES_PER_GRP; i++) begin : g_line
    irql_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_i   (in_i[i]),
      .ready_i(ready_i),
      .level_i(level_i[i]),
      .ack_i  (ack_i[i]),
      .req_o  (req_o[i])
    );
  end
endmodule

// File: rtl/irql_ack_decode.sv
module irql_ack_decode
  import irql_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  input  logic [PIN_W-1:0] ack_pin,
  output line_vec_t        ack_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
    assign ack_o[i] = ack_valid && (ack_pin == PIN_W'(i));
  end

  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  p_ack_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ($countones(ack_o) == 1));
endmodule

// File: rtl/irql_elc_regs.sv
module irql_elc_regs
  import irql_pkg::*;
#(
  parameter line_vec_t WR_MASK = DEFAULT_WR_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] wr_grp,
  input  grp_vec_t         wr_data,
  input  logic [GRP_W-1:0] rd_grp,
  output grp_vec_t         rd_data,
  output line_vec_t        level_o
);
  logic [NUM_GRP-1:0][LINES_PER_GRP-1:0] sel_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
    localparam grp_vec_t GMASK = WR_MASK[g*LINES_PER_GRP +: LINES_PER_GRP];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[g] <= '0;
      else if (wr_en && (wr_grp == GRP_W'(g)))
        sel_q[g] <= wr_data & GMASK;
    end
    assign level_o[g*LINES_PER_GRP +: LINES_PER_GRP] = sel_q[g];
  end

  assign rd_data = sel_q[rd_grp];

  p_locked_edge_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o & ~WR_MASK) == '0);
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/irq_trigger_latch.sv
module irq_trigger_latch
  import irql_pkg::*;
#(
  parameter line_vec_t WR_MASK = DEFAULT_WR_MASK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        irq_in,
  input  logic [1:0]         grp_ready,
  input  logic               cfg_wr_en,
  input  logic [0:0]         cfg_wr_grp,
  input  logic [7:0]         cfg_wr_data,
  input  logic [0:0]         cfg_rd_grp,
  output logic [7:0]         cfg_rd_data,
  input  logic               ack_valid,
  input  logic [3:0]         ack_pin,
  output logic [15:0]        req_out
);
  line_vec_t level_w;
  line_vec_t ack_w;

  irql_elc_regs #(.WR_MASK(WR_MASK)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .wr_grp (cfg_wr_grp),
    .wr_data(cfg_wr_data),
    .rd_grp (cfg_rd_grp),
    .rd_data(cfg_rd_data),
    .level_o(level_w)
  );

  irql_ack_decode u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_valid(ack_valid),
    .ack_pin  (ack_pin),
    .ack_o    (ack_w)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    irql_group u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_i   (irq_in[g*LINES_PER_GRP +: LINES_PER_GRP]),
      .ready_i(grp_ready[g]),
      .level_i(level_w[g*LINES_PER_GRP +: LINES_PER_GRP]),
      .ack_i  (ack_w[g*LINES_PER_GRP +: LINES_PER_GRP]),
      .req_o  (req_out[g*LINES_PER_GRP +: LINES_PER_GRP])
    );
  end

  p_reset_clear_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_out == '0));
endmodule

// File: tb/sim_irq_trigger_latch.sv
module sim_irq_trigger_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [1:0]  grp_ready = '0;
  logic        cfg_wr_en = 1'b0;
  logic [0:0]  cfg_wr_grp = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic [0:0]  cfg_rd_grp = '0;
  logic [7:0]  cfg_rd_data;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_pin = '0;
  logic [15:0] req_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_req, m_prev;
  logic [7:0]  m_elc [2];

  irq_trigger_latch u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .grp_ready(grp_ready),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_grp(cfg_wr_grp), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_grp(cfg_rd_grp), .cfg_rd_data(cfg_rd_data),
    .ack_valid(ack_valid), .ack_pin(ack_pin), .req_out(req_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] wmask(input int g);
    return (g == 0) ? 8'hF8 : 8'hDE;
  endfunction

  // reference update from the requirements, applied at each rising edge
  task automatic model_edge();
    logic [15:0] nreq;
    nreq = m_req;
    for (int i = 0; i < 16; i++) begin
      int g;
      logic lvl, rdy, rise, fall, setr, clr;
      g = i / 8;
      lvl = m_elc[g][i%8];
      rdy = grp_ready[g];
      rise = rdy & irq_in[i] & ~m_prev[i];
      fall = rdy & ~irq_in[i] & m_prev[i];
      setr = rise | (rdy & lvl & irq_in[i]);
      clr = (fall & lvl) | (ack_valid && ack_pin == 4'(i) && !irq_in[i]);
      if (setr) nreq[i] = 1'b1;
      else if (clr) nreq[i] = 1'b0;
    end
    m_req = nreq;
    m_prev = irq_in;
    if (cfg_wr_en) m_elc[cfg_wr_grp] = cfg_wr_data & wmask(int'(cfg_wr_grp));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int g, input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_wr_grp = 1'(g); cfg_wr_data = d;
    cycle();
    cfg_wr_en = 1'b0;
  endtask

  task automatic ack(input int p);
    ack_valid = 1'b1; ack_pin = 4'(p);
    cycle();
    ack_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_req = '0; m_prev = '0; m_elc[0] = '0; m_elc[1] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    grp_ready = 2'b11;
    chk(req_out, 16'h0, "R10 reset requests");
    cfg_rd_grp = 1'b0; #1 chk({8'h0, cfg_rd_data}, 16'h0, "R7 grp0 reset value");
    cfg_rd_grp = 1'b1; #1 chk({8'h0, cfg_rd_data}, 16'h0, "R7 grp1 reset value");

    wr(0, 8'hFF);
    cfg_rd_grp = 1'b0; #1 chk({8'h0, cfg_rd_data}, 16'h00F8, "R5 grp0 masked readback");
    wr(1, 8'hFF);
    cfg_rd_grp = 1'b1; #1 chk({8'h0, cfg_rd_data}, 16'h00DE, "R6 grp1 masked readback");

    // R1 R8: pulse on edge line 0 (forced edge)
    irq_in[0] = 1'b1; cycle();
    chk(16'(req_out[0]), 16'h1, "R1 rise sets line 0");
    irq_in[0] = 1'b0; cycle(); cycle();
    chk(16'(req_out[0]), 16'h1, "R8 pulse stays latched");
    ack(0);
    chk(16'(req_out[0]), 16'h0, "R4 ack with low input clears");

    // R2 R3: level line 3
    irq_in[3] = 1'b1; cycle();
    chk(16'(req_out[3]), 16'h1, "R2 level set");
    ack(3);
    chk(16'(req_out[3]), 16'h1, "R2 level held through ack");
    irq_in[3] = 1'b0; cycle();
    chk(16'(req_out[3]), 16'h0, "R3 level falling clears");

    // R3 edge keeps; R4 ack with high input keeps
    irq_in[8] = 1'b1; cycle();
    ack(8);
    chk(16'(req_out[8]), 16'h1, "R4 ack with high input keeps");
    irq_in[8] = 1'b0; cycle();
    chk(16'(req_out[8]), 16'h1, "R3 edge line keeps after fall");
    ack(8);
    chk(16'(req_out[8]), 16'h0, "R4 ack clears line 8");

    // R9: not ready group 1
    grp_ready = 2'b01;
    irq_in[13] = 1'b1; cycle();
    chk(16'(req_out[13]), 16'h0, "R9 ignored while not ready");
    grp_ready = 2'b11; cycle();
    chk(16'(req_out[13]), 16'h0, "R9 no edge on becoming ready");
    irq_in[13] = 1'b0; cycle();
    chk(req_out, m_req, "R9 directed model agreement");

    // randomized phase: R1 R2 R3 R4 R7 against the model
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      irq_in = irq_in ^ 16'($urandom & $urandom & $urandom);
      grp_ready = ($urandom % 12 == 0) ? 2'($urandom) : 2'b11;
      ack_valid = ($urandom % 3 == 0);
      ack_pin = 4'($urandom);
      cfg_wr_en = ($urandom % 25 == 0);
      cfg_wr_grp = 1'($urandom);
      cfg_wr_data = 8'($urandom);
      cfg_rd_grp = 1'($urandom);
      cycle();
      chk(req_out, m_req, "rand R1 R2 R3 R4 requests");
      chk({8'h0, cfg_rd_data}, {8'h0, m_elc[cfg_rd_grp]}, "rand R7 readback");
    end
    ack_valid = 1'b0; cfg_wr_en = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule